// File: doc/BRIEF.md
# Two-Way Conditional Token Steering

This block takes one handshaked token whose payload includes a one-bit condition, and offers it to exactly one of two valid/ready output channels. A condition of 1 routes the token to the "taken" side, and a condition of 0 routes it to the "not-taken" side.

Only the chosen side sees valid asserted. The input is acknowledged only when that chosen side is ready. The side that was not chosen cannot stall the input or release it.

Any data payload that travels with the condition is placed on both output data buses. The two outputs differ only in their valid signals. The block holds no state, so every output follows its inputs within the same cycle. It is meant to sit between pipeline stages in a dataflow fabric, where the control path needs to split on a predicate.

Top module: `cond_steer`

## Requirements
- R1: `tk_valid` is high exactly when `in_valid` is high and `in_cond` is 1.
- R2: `nt_valid` is high exactly when `in_valid` is high and `in_cond` is 0.
- R3: While `in_valid` is high, exactly one of `tk_valid` and `nt_valid` is high. While `in_valid` is low, neither is high.
- R4: With `in_valid` high and `in_cond` = 1, `in_ready` equals `tk_ready`.
- R5: With `in_valid` high and `in_cond` = 0, `in_ready` equals `nt_ready`.
- R6: With `in_valid` low, `in_ready` is 0 for every combination of `tk_ready` and `nt_ready`.
- R7: The ready of the unselected output has no effect on `in_ready`. The bench checks this by toggling that ready alone and observing that `in_ready` does not change.
- R8: `tk_data` and `nt_data` both equal `in_data` bit for bit, whatever the values of `in_cond` and `in_valid`.
- R9: The block has no storage. A change on any input shows up on the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Input token present |
| in_cond | input | 1 | Steering condition (1 routes to the taken side) |
| in_data | input | DATA_W | Payload that travels with the condition |
| in_ready | output | 1 | Input token accepted this cycle |
| tk_valid | output | 1 | Token offered on the taken side |
| tk_ready | input | 1 | Taken-side consumer can accept |
| tk_data | output | DATA_W | Payload on the taken side |
| nt_valid | output | 1 | Token offered on the not-taken side |
| nt_ready | input | 1 | Not-taken-side consumer can accept |
| nt_data | output | DATA_W | Payload on the not-taken side |

## Verification
The bench overrides `DATA_W` to 12. With that width, payloads whose upper and lower bits differ show up any dropped, swapped or truncated bit on either data bus.

Random cycles draw all sixteen combinations of valid, condition and the two readies many times over. Directed steps then hold the selected side fixed and flip only the other side's ready, to expose any leak from the unselected ready into the acknowledge.

Outputs are sampled between input changes with no clock edge in between. This confirms that nothing is registered on the path.

// File: rtl/cond_steer_pkg.sv
package cond_steer_pkg;

    typedef enum logic {
        LANE_NT = 1'b0,
        LANE_TK = 1'b1
    } lane_e;

    localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/cs_lane_gate.sv
module cs_lane_gate
    import cond_steer_pkg::*;
(
    input  logic                 tok_valid,
    input  logic                 tok_cond,
    output logic [NUM_LANES-1:0] lane_valid
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam lane_e LANE = lane_e'(g);
        always_comb begin
            lane_valid[g] = tok_valid && (lane_e'(tok_cond) == LANE);
        end
    end
endmodule

// File: rtl/cs_ready_pick.sv
module cs_ready_pick
    import cond_steer_pkg::*;
(
    input  logic                 tok_valid,
    input  logic                 tok_cond,
    input  logic [NUM_LANES-1:0] lane_ready,
    output logic                 tok_ready
);
    logic picked_d;

    always_comb begin
        picked_d  = lane_ready[tok_cond];
        tok_ready = picked_d && tok_valid;
    end
endmodule

// File: rtl/cs_payload_fan.sv
module cs_payload_fan
    import cond_steer_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0]                 src,
    output logic [NUM_LANES-1:0][DATA_W-1:0]  dst
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_fan
        assign dst[g] = src;
    end
endmodule

// File: rtl/cond_steer.sv
module cond_steer
    import cond_steer_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              in_valid,
    input  logic              in_cond,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tk_valid,
    input  logic              tk_ready,
    output logic [DATA_W-1:0] tk_data,
    output logic              nt_valid,
    input  logic              nt_ready,
    output logic [DATA_W-1:0] nt_data
);
    logic [NUM_LANES-1:0]             lane_valid;
    logic [NUM_LANES-1:0]             lane_ready;
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_data;

    assign lane_ready[LANE_TK] = tk_ready;
    assign lane_ready[LANE_NT] = nt_ready;

    cs_lane_gate u_gate (
        .tok_valid  (in_valid),
        .tok_cond   (in_cond),
        .lane_valid (lane_valid)
    );

    cs_ready_pick u_pick (
        .tok_valid  (in_valid),
        .tok_cond   (in_cond),
        .lane_ready (lane_ready),
        .tok_ready  (in_ready)
    );

    cs_payload_fan #(.DATA_W(DATA_W)) u_fan (
        .src (in_data),
        .dst (lane_data)
    );

    assign tk_valid = lane_valid[LANE_TK];
    assign nt_valid = lane_valid[LANE_NT];
    assign tk_data  = lane_data[LANE_TK];
    assign nt_data  = lane_data[LANE_NT];
endmodule

// File: rtl/cond_steer_chk.sv
module cond_steer_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              in_valid,
    input logic              in_cond,
    input logic [DATA_W-1:0] in_data,
    input logic              in_ready,
    input logic              tk_valid,
    input logic              tk_ready,
    input logic [DATA_W-1:0] tk_data,
    input logic              nt_valid,
    input logic              nt_ready,
    input logic [DATA_W-1:0] nt_data
);
    always_comb begin
        assert_tk_valid_R1: assert (tk_valid == (in_valid && in_cond));
        assert_nt_valid_R2: assert (nt_valid == (in_valid && !in_cond));
        assert_one_hot_R3: assert ($countones({tk_valid, nt_valid}) == (in_valid ? 1 : 0));
        assert_ack_taken_R4: assert (!(in_valid && in_cond) || (in_ready == tk_ready));
        assert_ack_nt_R5: assert (!(in_valid && !in_cond) || (in_ready == nt_ready));
        assert_idle_ack_R6: assert (in_valid || !in_ready);
        assert_ack_needs_valid_out_R7: assert (!in_ready || (tk_valid && tk_ready) || (nt_valid && nt_ready));
        assert_payload_R8: assert ((tk_data == in_data) && (nt_data == in_data));
    end
endmodule

bind cond_steer cond_steer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cond_steer_test.sv
module cond_steer_test;
    localparam int unsigned DW = 12;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          in_valid, in_cond, tk_ready, nt_ready;
    logic [DW-1:0] in_data;
    logic          in_ready, tk_valid, nt_valid;
    logic [DW-1:0] tk_data, nt_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    cond_steer #(.DATA_W(DW)) uut (
        .in_valid(in_valid), .in_cond(in_cond), .in_data(in_data), .in_ready(in_ready),
        .tk_valid(tk_valid), .tk_ready(tk_ready), .tk_data(tk_data),
        .nt_valid(nt_valid), .nt_ready(nt_ready), .nt_data(nt_data)
    );

    function automatic logic exp_ready(logic v, logic c, logic tr, logic nr);
        return v & (c ? tr : nr);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic c, logic tr, logic nr, logic [DW-1:0] d);
        in_valid = v; in_cond = c; tk_ready = tr; nt_ready = nr; in_data = d;
        #1;
    endtask

    task automatic check_all();
        chk("R1", 32'(tk_valid), 32'(in_valid & in_cond));
        chk("R2", 32'(nt_valid), 32'(in_valid & ~in_cond));
        chk("R3", 32'(tk_valid + nt_valid), 32'(in_valid));
        if (in_valid && in_cond)  chk("R4", 32'(in_ready), 32'(tk_ready));
        if (in_valid && !in_cond) chk("R5", 32'(in_ready), 32'(nt_ready));
        if (!in_valid)            chk("R6", 32'(in_ready), 32'd0);
        chk("R8", 32'(tk_data), 32'(in_data));
        chk("R8", 32'(nt_data), 32'(in_data));
    endtask

    initial begin
        int seed;
        logic r_before;
        seed = 32'h5eed_0421;
        void'($urandom(seed));
        drive(0, 0, 0, 0, '0);
        @(negedge clk);
        chk("R6 reset idle", 32'({in_ready, tk_valid, nt_valid}), 32'd0);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            drive(i[0], i[1], i[2], i[3], DW'(12'hA5C ^ i));
            check_all();
        end

        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            @(negedge clk);
            r = 4'($urandom);
            drive(r[0], r[1], r[2], r[3], DW'($urandom));
            check_all();
            chk("R4/R5 model", 32'(in_ready), 32'(exp_ready(r[0], r[1], r[2], r[3])));
        end

        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                drive(1, c[0], s[0], s[0], 12'hF0F);
                r_before = in_ready;
                if (c == 1) drive(1, 1, s[0], ~s[0], 12'hF0F);
                else        drive(1, 0, ~s[0], s[0], 12'hF0F);
                chk("R7 unselected ready", 32'(in_ready), 32'(r_before));
            end
        end

        @(negedge clk);
        drive(1, 1, 1, 0, 12'h123);
        chk("R9 same-cycle taken", 32'({tk_valid, in_ready}), 32'b11);
        drive(1, 0, 1, 0, 12'hEDC);
        chk("R9 same-cycle flip", 32'({tk_valid, nt_valid, in_ready}), 32'b010);
        chk("R9 same-cycle data", 32'(nt_data), 32'h0EDC);
        drive(0, 1, 1, 1, 12'hFFF);
        chk("R6 all ready idle", 32'(in_ready), 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule